// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block counts up on a slow time base taken from the oscillator clock. Software has to prove that it is alive by writing a two-step key to the block before an 8-bit up-counter reaches its top value. If the counter gets there first, the block drives an active-low pulse that is a fixed number of oscillator cycles long. A route bit chooses where that pulse goes: the core reset output or an interrupt output, which can wake a sleeping core.

The block is programmed over a simple one-cycle write port that selects either the control word or the key register. Every control write has to carry a fixed check pattern. A write without it is treated as a fault, and it raises the reset pulse at once. While the reset pulse is low, the block holds its own state at the reset values. A clock-failed flag from the clock supervisor freezes the time base, so a degraded clock cannot age the counter.

Top module: `keyed_wdt`

## Requirements
- R1: After `rst_ni` is released, `count_o` is 0 and both `wd_rst_no` and `wd_irq_no` are high. The control word defaults to divide code 0, counting enabled, and the reset route.
- R2: Control word bits [2:0] select the divider. Codes 0 and 1 divide by 1, and code k from 2 to 7 divides by 2^(k-1). A base stage divides by BASE_DIV. It feeds a free-running 6-bit stage, and the counter advances on each base tick at which the low (k-1) bits of that stage are all ones.
- R3: A key-register write (`wr_sel_i`=1) of 0x55 arms the key logic. A later write of 0xAA clears `count_o` at that edge and disarms. Any other key value leaves the armed state as it is. A 0xAA write while unarmed has no effect. When a clear and a count step fall on the same edge, the clear wins and no expiry occurs.
- R4: On the edge where the counter steps from 0xFE to 0xFF, a pulse starts. It goes to `wd_irq_no` when control bit [7] is 1 and to `wd_rst_no` when it is 0.
- R5: Every pulse stays low for exactly PULSE_W oscillator cycles.
- R6: A control write (`wr_sel_i`=0) whose bits [5:3] are not 3'b101 drives `wd_rst_no` low from the next cycle and does not update the control word. With 3'b101, the control word is updated.
- R7: When control bit [6] is 1, both the counter and the time base stay frozen.
- R8: While `clk_fail_i` is high, both the counter and the time base stay frozen.
- R9: While `wd_rst_no` is low, the counter, the time base, the key state and the control word are held at their reset values, and all writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | One-cycle register write strobe |
| wr_sel_i | input | 1 | Target: 0 control word, 1 key register |
| wr_data_i | input | 8 | Write data |
| clk_fail_i | input | 1 | Input clock has failed |
| wd_rst_no | output | 1 | Active-low watchdog reset pulse |
| wd_irq_no | output | 1 | Active-low watchdog interrupt pulse |
| count_o | output | CNT_W | Current counter value |

## Verification
The bench goes after key ordering: stray values between 0x55 and 0xAA, and an 0xAA with no arming. A design that got this wrong would either clear on 0xAA alone or forget that it had been armed. It drives writes during a running reset pulse; a block that accepted them would come out of reset halted or armed. It also tests both expiry routes and bad check patterns. A misrouted or mis-stretched pulse shows up as a wrong output level or a low time off by one. The prescaler codes are run against an independent cycle model, so an error in the divide decode drifts the counter away from the expected value.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam int          PRE_W    = 6;
  localparam logic [2:0]  CHECK_OK = 3'b101;
  localparam logic [7:0]  KEY_ARM  = 8'h55;
  localparam logic [7:0]  KEY_FIRE = 8'hAA;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_st_e;

  // Control word layout, MSB first.
  typedef struct packed {
    logic       to_irq;
    logic       halt;
    logic [2:0] chk;
    logic [2:0] psel;
  } ctrl_t;

  // Bits of the prescale stage that must all be one for a count step.
  function automatic logic [PRE_W-1:0] pre_mask(input logic [2:0] code);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i + 2 <= int'(code)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/kwd_tick_gen.sv
module kwd_tick_gen
  import kwd_pkg::*;
#(
  parameter int BASE_DIV = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic       run_i,
  input  logic [2:0] psel_i,
  output logic       tick_o
);

  localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam logic [BW-1:0] BLAST = BW'(BASE_DIV - 1);

  logic [BW-1:0]    base_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             base_tick;

  assign mask      = pre_mask(psel_i);
  assign base_tick = run_i && (base_q == BLAST);
  assign tick_o    = base_tick && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      pre_q  <= '0;
    end else if (hold_i) begin
      base_q <= '0;
      pre_q  <= '0;
    end else begin
      if (run_i) base_q <= (base_q == BLAST) ? '0 : base_q + 1'b1;
      if (base_tick) pre_q <= pre_q + 1'b1;
    end
  end

  // R7/R8: a stopped time base keeps its prescale phase
  p_prescale_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !hold_i) |=> $stable(pre_q))
    else $error("prescale stage moved while stopped");

endmodule

// File: rtl/kwd_key_fsm.sv
module kwd_key_fsm
  import kwd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic       key_wr_i,
  input  logic [7:0] key_i,
  output logic       clear_o
);

  key_st_e st_q;

  assign clear_o = key_wr_i && !hold_i && (key_i == KEY_FIRE) && (st_q == KEY_ARMED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= KEY_IDLE;
    end else if (hold_i) begin
      st_q <= KEY_IDLE;
    end else if (key_wr_i) begin
      if (key_i == KEY_ARM)       st_q <= KEY_ARMED;
      else if (key_i == KEY_FIRE) st_q <= KEY_IDLE;
    end
  end

  // R3: a service clear consumes the arming
  p_clear_disarms_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> (st_q == KEY_IDLE))
    else $error("key logic still armed after clear");

  // R3: a stray key value keeps the armed state
  p_stray_key_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && !hold_i && key_i != KEY_ARM && key_i != KEY_FIRE) |=> $stable(st_q))
    else $error("stray key changed key state");

endmodule

// File: rtl/kwd_pulse_gen.sv
module kwd_pulse_gen #(
  parameter int WIDTH = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_no
);

  localparam int RW = $clog2(WIDTH + 1);
  localparam logic [RW-1:0] RLOAD = RW'(WIDTH);

  logic [RW-1:0] rem_q;
  logic          low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      low_q <= 1'b0;
    end else if (trig_i) begin
      rem_q <= RLOAD;
      low_q <= 1'b1;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
      low_q <= (rem_q != RW'(1));
    end
  end

  assign pulse_no = !low_q;

  // Cycles since the last trigger, saturating, for the width check.
  logic [RW:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      since_q <= '0;
    else if (trig_i)                  since_q <= '0;
    else if (since_q != (RW+1)'(WIDTH)) since_q <= since_q + 1'b1;
  end

  // R5: pulse ends exactly WIDTH cycles after its trigger
  p_pulse_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_no) |-> (since_q == (RW+1)'(WIDTH)))
    else $error("pulse width wrong");

  // R5: a trigger always lowers the output next cycle
  p_trig_lowers_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> !pulse_no)
    else $error("trigger did not start pulse");

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwd_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int BASE_DIV = 512,
  parameter int PULSE_W  = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [7:0]       wr_data_i,
  input  logic             clk_fail_i,
  output logic             wd_rst_no,
  output logic             wd_irq_no,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_PRE_TOP = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam ctrl_t CTRL_RST = '{to_irq: 1'b0, halt: 1'b0, chk: 3'b000, psel: 3'b000};

  ctrl_t            ctrl_q;
  ctrl_t            wr_word;
  logic [CNT_W-1:0] cnt_q;

  // Named internal events.
  logic hold;
  logic ctrl_wr;
  logic bad_check;
  logic good_ctrl;
  logic key_wr;
  logic run;
  logic tick;
  logic svc_clear;
  logic expire;
  logic rst_trig;
  logic irq_trig;

  assign wr_word   = ctrl_t'(wr_data_i);
  assign hold      = !wd_rst_no;
  assign ctrl_wr   = wr_en_i && !wr_sel_i && !hold;
  assign bad_check = ctrl_wr && (wr_word.chk != CHECK_OK);
  assign good_ctrl = ctrl_wr && (wr_word.chk == CHECK_OK);
  assign key_wr    = wr_en_i && wr_sel_i && !hold;
  assign run       = !ctrl_q.halt && !clk_fail_i && !hold;
  assign expire    = tick && (cnt_q == CNT_PRE_TOP) && !svc_clear;
  assign rst_trig  = bad_check || (expire && !ctrl_q.to_irq);
  assign irq_trig  = expire && ctrl_q.to_irq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= CTRL_RST;
    else if (hold)      ctrl_q <= CTRL_RST;
    else if (good_ctrl) ctrl_q <= wr_word;
  end

  kwd_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .run_i  (run),
    .psel_i (ctrl_q.psel),
    .tick_o (tick)
  );

  kwd_key_fsm u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (hold),
    .key_wr_i (key_wr),
    .key_i    (wr_data_i),
    .clear_o  (svc_clear)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (hold || svc_clear) cnt_q <= '0;
    else if (tick)              cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  kwd_pulse_gen #(.WIDTH(PULSE_W)) u_rst_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (rst_trig),
    .pulse_no (wd_rst_no)
  );

  kwd_pulse_gen #(.WIDTH(PULSE_W)) u_irq_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (irq_trig),
    .pulse_no (wd_irq_no)
  );

  // R6: bad check pattern forces the reset pulse
  p_bad_check_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_check |=> !wd_rst_no)
    else $error("bad check did not reset");

  // R3: service clear empties the counter
  p_service_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_clear |=> (count_o == '0))
    else $error("service clear missed");

  // R4: expiry goes to the routed output
  p_expire_route_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> ($past(ctrl_q.to_irq) ? !wd_irq_no : !wd_rst_no))
    else $error("expiry pulse misrouted");

  // R8: a failed clock freezes the counter
  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_fail_i && !svc_clear && !hold) |=> $stable(count_o))
    else $error("counter moved on failed clock");

  // R7: the halt bit freezes the counter
  p_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.halt && !svc_clear && !hold) |=> $stable(count_o))
    else $error("counter moved while halted");

  // R9: held at zero during the reset pulse
  p_hold_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wd_rst_no && $past(!wd_rst_no)) |-> (count_o == '0))
    else $error("counter not held during reset pulse");

endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;

  localparam int BD = 4;
  localparam int PW = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       clk_fail = 1'b0;
  logic       wd_rst_n;
  logic       wd_irq_n;
  logic [7:0] count;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  keyed_wdt #(.CNT_W(8), .BASE_DIV(BD), .PULSE_W(PW)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .clk_fail_i (clk_fail),
    .wd_rst_no  (wd_rst_n),
    .wd_irq_no  (wd_irq_n),
    .count_o    (count)
  );

  // Reference model state, derived from the requirements.
  int m_cnt, m_base, m_pre, m_rrem, m_irem;
  bit m_arm, m_halt, m_irq;
  int m_psel;

  function automatic int div_mask(input int code);
    if (code < 2) return 0;
    return (1 << (code - 1)) - 1;
  endfunction

  always @(posedge clk) begin
    bit hold, cw, bad, good, clr, run, btick, tk, ex, rt, it;
    if (!rst_n) begin
      m_cnt = 0; m_base = 0; m_pre = 0; m_rrem = 0; m_irem = 0;
      m_arm = 0; m_halt = 0; m_irq = 0; m_psel = 0;
    end else begin
      hold  = (m_rrem != 0);
      cw    = wr_en && !wr_sel && !hold;
      bad   = cw && (wr_data[5:3] != 3'b101);
      good  = cw && !bad;
      clr   = wr_en && wr_sel && !hold && (wr_data == 8'hAA) && m_arm;
      run   = !m_halt && !clk_fail && !hold;
      btick = run && (m_base == BD - 1);
      tk    = btick && ((m_pre & div_mask(m_psel)) == div_mask(m_psel));
      ex    = tk && (m_cnt == 254) && !clr;
      rt    = bad || (ex && !m_irq);
      it    = ex && m_irq;
      if (hold) m_arm = 0;
      else if (wr_en && wr_sel) begin
        if (wr_data == 8'h55) m_arm = 1;
        else if (wr_data == 8'hAA) m_arm = 0;
      end
      if (hold) begin m_halt = 0; m_irq = 0; m_psel = 0; end
      else if (good) begin m_irq = wr_data[7]; m_halt = wr_data[6]; m_psel = int'(wr_data[2:0]); end
      if (hold) begin m_base = 0; m_pre = 0; end
      else begin
        if (run) m_base = (m_base == BD - 1) ? 0 : m_base + 1;
        if (btick) m_pre = (m_pre + 1) & 63;
      end
      if (hold || clr) m_cnt = 0;
      else if (tk) m_cnt = (m_cnt + 1) & 255;
      if (rt) m_rrem = PW; else if (m_rrem != 0) m_rrem = m_rrem - 1;
      if (it) m_irem = PW; else if (m_irem != 0) m_irem = m_irem - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(int'(count) == m_cnt, {cur_req, " count"}, int'(count), m_cnt);
    chk(wd_rst_n == (m_rrem == 0), {cur_req, " rst"}, int'(wd_rst_n), int'(m_rrem == 0));
    chk(wd_irq_n == (m_irem == 0), {cur_req, " irq"}, int'(wd_irq_n), int'(m_irem == 0));
  endtask

  task automatic cyc(input bit en, input bit sel, input logic [7:0] d, input bit fail);
    wr_en = en; wr_sel = sel; wr_data = d; clk_fail = fail;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0);
  endtask

  task automatic wait_rst_end();
    for (int i = 0; i < 4 * PW && !wd_rst_n; i++) idle(1);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lows;
    logic [7:0] snap;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk(count == 8'd0, "R1 count", int'(count), 0);
    chk(wd_rst_n && wd_irq_n, "R1 pulses high", int'({wd_rst_n, wd_irq_n}), 3);
    idle(4);

    // R2 each divider code
    cur_req = "R2";
    for (int c = 0; c < 8; c++) begin
      cyc(1, 0, 8'h28 | 8'(c), 0);
      idle(300);
      cyc(1, 1, 8'h55, 0);
      cyc(1, 1, 8'hAA, 0);
    end

    // R3 key ordering
    cur_req = "R3";
    cyc(1, 0, 8'h28, 0);
    idle(60);
    snap = count;
    cyc(1, 1, 8'hAA, 0);
    chk(count != 8'd0 && count >= snap, "R3 unarmed AA ignored", int'(count), int'(snap));
    cyc(1, 1, 8'h55, 0);
    cyc(1, 1, 8'h13, 0);
    cyc(1, 0, 8'h29, 0);
    cyc(1, 1, 8'hAA, 0);
    chk(count == 8'd0, "R3 armed clear", int'(count), 0);
    idle(40);
    cyc(1, 1, 8'hAA, 0);
    chk(count != 8'd0, "R3 second AA ignored", int'(count), 1);

    // R4 expiry to reset route
    cur_req = "R4";
    cyc(1, 0, 8'h28, 0);
    for (int i = 0; i < 1500 && wd_rst_n; i++) idle(1);
    chk(!wd_rst_n && wd_irq_n, "R4 reset route", int'({wd_rst_n, wd_irq_n}), 1);
    // R5 width of that pulse
    cur_req = "R5";
    lows = 0;
    for (int i = 0; i < 4 * PW && !wd_rst_n; i++) begin lows++; idle(1); end
    chk(lows == PW, "R5 width", lows, PW);

    // R4 expiry to interrupt route
    cur_req = "R4";
    cyc(1, 0, 8'hA8, 0);
    for (int i = 0; i < 1500 && wd_irq_n; i++) idle(1);
    chk(!wd_irq_n && wd_rst_n, "R4 irq route", int'({wd_rst_n, wd_irq_n}), 2);
    cur_req = "R5";
    lows = 0;
    for (int i = 0; i < 4 * PW && !wd_irq_n; i++) begin lows++; idle(1); end
    chk(lows == PW, "R5 irq width", lows, PW);

    // R6 bad check pattern
    cur_req = "R6";
    idle(20);
    cyc(1, 0, 8'hC8, 0);
    chk(!wd_rst_n, "R6 bad check resets", int'(wd_rst_n), 0);

    // R9 writes ignored during hold
    cur_req = "R9";
    idle(2);
    cyc(1, 0, 8'h68, 0);
    cyc(1, 1, 8'h55, 0);
    chk(count == 8'd0, "R9 held count", int'(count), 0);
    wait_rst_end();
    idle(20);
    chk(count != 8'd0, "R9 halt write ignored", int'(count), 5);
    cyc(1, 1, 8'hAA, 0);
    chk(count != 8'd0, "R9 arm during hold ignored", int'(count), 5);

    // R7 halt
    cur_req = "R7";
    cyc(1, 0, 8'h6A, 0);
    snap = count;
    idle(100);
    chk(count == snap, "R7 halted", int'(count), int'(snap));
    cyc(1, 0, 8'h28, 0);
    idle(20);

    // R8 clock failure
    cur_req = "R8";
    snap = count;
    for (int i = 0; i < 100; i++) cyc(0, 0, 8'h00, 1);
    chk(count == snap, "R8 stalled", int'(count), int'(snap));
    idle(20);

    // Mixed random traffic against the model
    cur_req = "R2";
    for (int i = 0; i < 30000; i++) begin
      int r;
      logic [7:0] d;
      r = int'($urandom % 64);
      if (r == 0) begin
        d = 8'(($urandom % 2) ? 8'hA8 : 8'h28) | 8'($urandom % 4);
        if ($urandom % 8 == 0) d = 8'($urandom);
        if ($urandom % 10 == 0) d = d | 8'h40;
        cyc(1, 0, d, 0);
      end else if (r == 1) begin
        case ($urandom % 3)
          0: d = 8'h55;
          1: d = 8'hAA;
          default: d = 8'($urandom);
        endcase
        cyc(1, 1, d, 0);
      end else begin
        cyc(0, 0, 8'h00, ($urandom % 16) == 0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule